// File: doc/BRIEF.md
# Dual-Channel Transmit Queue with Length-Triggered Launch

This block sits between a processor's 32-bit register port and a byte-wide transmit path. It holds two independent byte queues behind one shared data register. Software first chooses a channel through a select register. It then writes 32-bit words into that channel and programs a frame length for it. A write to the channel's launch register sends the frame.

The launched bytes leave on a byte output, one per clock, marked with start-of-frame and end-of-frame flags. The launched length is the programmed length, cut down to the bytes actually queued. After a launch, the channel is emptied and its length register returns to zero. Each launch sets a per-channel status bit. The interrupt line is the OR of status AND mask, and status bits are cleared by writing 1 to them.

Top module: `dual_txq`

Register map (word index on `wrAddr`/`rdAddr`):

| Index | Register | Notes |
|---|---|---|
| 0 | control | bit 0 enables transmit; bit 31 is a self-clearing soft reset |
| 1 | mode | stored and read back only |
| 2 | channel select | |
| 3 | data | write only |
| 4 | length, channel 0 | |
| 5 | length, channel 1 | |
| 6 | launch, channel 0 | write only, bit 0 |
| 7 | launch, channel 1 | write only, bit 0 |
| 8 | interrupt mask | bits 1:0 |
| 9 | interrupt status | bits 1:0, write-1-to-clear |

Unlisted indices read 0.

## Requirements
- R1: A write to index 2 stores the value when it is below 2. Any other value stores channel 0. Index 2 reads back the stored channel.
- R2: A write to index 3 appends the word to the selected channel, byte 7:0 first and byte 31:24 last. The word is dropped when that channel has fewer than 4 free bytes. Free bytes are DEPTH minus the queued bytes minus any bytes reserved under R11.
- R3: A write to index 4 or 5 stores the value, clamped to DEPTH when it is larger. The register reads back the stored value.
- R4: A write with bit 0 set to index 6 or 7 launches that channel only under two conditions: control bit 0 is set, and no frame is being sent. Otherwise the write has no effect.
- R5: The launched length is the smaller of the channel's length register and its queued byte count. When this length is zero, the launch has no effect: no output, no status, no flush, and the length is kept.
- R6: After a launch, the channel holds no queued bytes and its length register reads 0.
- R7: A frame launched at clock edge k drives its bytes on edges k+1 through k+L, one per cycle, in queue order. `txValid` is high on each of these cycles, `txSof` marks the first byte and `txEof` the last. Outside a frame all three flags are low and `txData` is 0.
- R8: A launch sets status bit 0 for channel 0 or bit 1 for channel 1. Writing index 9 clears each status bit written as 1. `irq` is high exactly when a status bit and its mask bit are both set.
- R9: A write to index 8 sets the mask. `irq` follows the new mask from the next cycle.
- R10: `rst_n` low, or a control write with bit 31 set, clears mode, mask, status, channel select, both lengths, both queues and any frame in flight. A soft reset stores bits 30:0 of the written value into control. Control bit 31 always reads 0.
- R11: All bytes a channel held at launch time stay reserved until that frame's last byte has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register word index for writes |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Register word index for reads |
| rdData | output | 32 | Read data, combinational from `rdAddr` |
| txData | output | 8 | Transmitted byte |
| txValid | output | 1 | `txData` carries a frame byte |
| txSof | output | 1 | First byte of a frame |
| txEof | output | 1 | Last byte of a frame |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a frame's last byte leaving while a word is pushed into the same channel. The bench fills channel 0 to DEPTH, launches a short frame and pushes a word on every cycle of the stream. The pushes before the final byte must be dropped, and the push on the edge after the final byte must be kept. This is judged by the contents of the next frame from that channel.

The second pair is a launch of one channel arriving while the other channel's frame is still streaming. That launch must be ignored, with no status bit and no change to its queue. A random phase then mixes every register write against the cycle-accurate queue model on each clock.

// File: rtl/dual_txq_pkg.sv
package dual_txq_pkg;
  localparam int NUM_CH = 2;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_MODE  = 4'd1;
  localparam logic [3:0] A_CHSEL = 4'd2;
  localparam logic [3:0] A_DATA  = 4'd3;
  localparam logic [3:0] A_LEN0  = 4'd4;
  localparam logic [3:0] A_LEN1  = 4'd5;
  localparam logic [3:0] A_GO0   = 4'd6;
  localparam logic [3:0] A_GO1   = 4'd7;
  localparam logic [3:0] A_IMASK = 4'd8;
  localparam logic [3:0] A_ISTAT = 4'd9;

  // strobes from the register block to the queue datapath
  typedef struct packed {
    logic flush;
    logic push;
    logic pushCh;
    logic launch;
    logic launchCh;
  } txCmd_t;
endpackage

// File: rtl/dual_txq_regs.sv
module dual_txq_regs
  import dual_txq_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wrEn,
  input  logic [3:0]                   wrAddr,
  input  logic [31:0]                  wrData,
  input  logic [3:0]                   rdAddr,
  output logic [31:0]                  rdData,
  input  logic [NUM_CH-1:0][PW-1:0]    count,
  input  logic [NUM_CH-1:0][PW-1:0]    free,
  input  logic                         busy,
  output txCmd_t                       cmd,
  output logic [PW-1:0]                launchLen,
  output logic                         irq
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [31:0]              ctrlReg, modeReg;
  logic                     chSel;
  logic [NUM_CH-1:0][PW-1:0] lenReg;
  logic [NUM_CH-1:0]        maskReg, statReg;

  logic          softRst, goCh, goHit;
  logic [PW-1:0] lenIn, selLen, selCnt;

  assign softRst = wrEn && (wrAddr == A_CTRL) && wrData[31];
  assign goCh    = wrAddr[0];
  assign goHit   = wrEn && ((wrAddr == A_GO0) || (wrAddr == A_GO1)) &&
                   wrData[0] && ctrlReg[0] && !busy;
  assign selLen  = lenReg[goCh];
  assign selCnt  = count[goCh];
  assign launchLen = (selLen > selCnt) ? selCnt : selLen;
  assign lenIn   = (wrData > 32'(DEPTH)) ? DEPTH_P : wrData[PW-1:0];

  always_comb begin
    cmd          = '0;
    cmd.flush    = softRst;
    cmd.push     = wrEn && (wrAddr == A_DATA) && (free[chSel] >= PW'(4));
    cmd.pushCh   = chSel;
    cmd.launch   = goHit && (launchLen != '0);
    cmd.launchCh = goCh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      modeReg <= '0;
      chSel   <= 1'b0;
      lenReg  <= '0;
      maskReg <= '0;
      statReg <= '0;
    end else if (softRst) begin
      ctrlReg <= {1'b0, wrData[30:0]};
      modeReg <= '0;
      chSel   <= 1'b0;
      lenReg  <= '0;
      maskReg <= '0;
      statReg <= '0;
    end else begin
      if (cmd.launch) begin
        lenReg[cmd.launchCh]  <= '0;
        statReg[cmd.launchCh] <= 1'b1;
      end
      if (wrEn) begin
        case (wrAddr)
          A_CTRL:         ctrlReg <= wrData;
          A_MODE:         modeReg <= wrData;
          A_CHSEL:        chSel   <= (wrData < 32'(NUM_CH)) ? wrData[0] : 1'b0;
          A_LEN0, A_LEN1: lenReg[wrAddr[0]] <= lenIn;
          A_IMASK:        maskReg <= wrData[NUM_CH-1:0];
          A_ISTAT:        statReg <= statReg & ~wrData[NUM_CH-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq = |(statReg & maskReg);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL:  rdData = ctrlReg;
      A_MODE:  rdData = modeReg;
      A_CHSEL: rdData = 32'(chSel);
      A_LEN0:  rdData = 32'(lenReg[0]);
      A_LEN1:  rdData = 32'(lenReg[1]);
      A_IMASK: rdData = 32'(maskReg);
      A_ISTAT: rdData = 32'(statReg);
      default: ;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6 R8
    launch_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.launch && cmd.launchCh == 1'(c)) |=> (statReg[c] && lenReg[c] == '0));
    // R3
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lenReg[c] <= DEPTH_P);
  end
endmodule

// File: rtl/dual_txq_dpath.sv
module dual_txq_dpath
  import dual_txq_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int PW = $clog2(DEPTH) + 1,
  localparam int WORDS = DEPTH / 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  txCmd_t                    cmd,
  input  logic [31:0]               pushWord,
  input  logic [PW-1:0]             launchLen,
  output logic [NUM_CH-1:0][PW-1:0] count,
  output logic [NUM_CH-1:0][PW-1:0] free,
  output logic                      busy,
  output logic [7:0]                txData,
  output logic                      txValid,
  output logic                      txSof,
  output logic                      txEof
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [NUM_CH-1:0][PW-1:0] headPtr;
  logic [NUM_CH-1:0][31:0]   rdWord;
  logic [PW-1:0]             sPtr, sRem;
  logic                      sCh, sFirst;
  logic                      lastByte;

  assign lastByte = busy && (sRem == PW'(1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [31:0]   mem [WORDS];
    logic [PW-1:0] wrPtr, rdPtr, resv;

    always_ff @(posedge clk) begin
      if (cmd.push && cmd.pushCh == 1'(c))
        mem[wrPtr[PW-2:2]] <= pushWord;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wrPtr <= '0;
        rdPtr <= '0;
        resv  <= '0;
      end else if (cmd.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        resv  <= '0;
      end else begin
        if (cmd.push && cmd.pushCh == 1'(c))
          wrPtr <= wrPtr + PW'(4);
        if (cmd.launch && cmd.launchCh == 1'(c)) begin
          rdPtr <= wrPtr;
          resv  <= wrPtr - rdPtr;
        end else if (lastByte && sCh == 1'(c)) begin
          resv  <= '0;
        end
      end
    end

    assign count[c]   = wrPtr - rdPtr;
    assign free[c]    = DEPTH_P - count[c] - resv;
    assign headPtr[c] = rdPtr;
    assign rdWord[c]  = mem[sPtr[PW-2:2]];

    // R2 R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, count[c]} + {1'b0, resv}) <= {1'b0, DEPTH_P});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sCh <= 1'b0; sPtr <= '0; sRem <= '0; sFirst <= 1'b0;
      txData <= '0; txValid <= 1'b0; txSof <= 1'b0; txEof <= 1'b0;
    end else if (cmd.flush) begin
      busy <= 1'b0; sRem <= '0; sFirst <= 1'b0;
      txData <= '0; txValid <= 1'b0; txSof <= 1'b0; txEof <= 1'b0;
    end else begin
      txValid <= busy;
      txSof   <= busy && sFirst;
      txEof   <= lastByte;
      txData  <= busy ? rdWord[sCh][8*sPtr[1:0] +: 8] : 8'h00;
      if (cmd.launch) begin
        busy   <= 1'b1;
        sCh    <= cmd.launchCh;
        sPtr   <= headPtr[cmd.launchCh];
        sRem   <= launchLen;
        sFirst <= 1'b1;
      end else if (busy) begin
        sFirst <= 1'b0;
        sPtr   <= sPtr + PW'(1);
        sRem   <= sRem - PW'(1);
        if (lastByte) busy <= 1'b0;
      end
    end
  end

  // R4
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.launch |-> !busy);
  // R7
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txSof || txEof) |-> txValid);
  // R7
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txEof |=> !txValid);
  // R7
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txEof && !cmd.flush) |=> txValid);
endmodule

// File: rtl/dual_txq.sv
module dual_txq
  import dual_txq_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [31:0] rdData,
  output logic [7:0]  txData,
  output logic        txValid,
  output logic        txSof,
  output logic        txEof,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH) + 1;

  txCmd_t                    cmd;
  logic [PW-1:0]             launchLen;
  logic [NUM_CH-1:0][PW-1:0] count, free;
  logic                      busy;

  dual_txq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .count(count), .free(free), .busy(busy),
    .cmd(cmd), .launchLen(launchLen), .irq(irq)
  );

  dual_txq_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .pushWord(wrData), .launchLen(launchLen),
    .count(count), .free(free), .busy(busy),
    .txData(txData), .txValid(txValid), .txSof(txSof), .txEof(txEof)
  );
endmodule

// File: tb/tb_dual_txq.sv
module tb_dual_txq;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [7:0]  txData;
  logic        txValid, txSof, txEof, irq;

  dual_txq #(.DEPTH(DEPTH)) dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int    nChecks = 0, nFail = 0, cyc = 0, rdIdx = 0;
  bit    chkOn = 1'b0;
  string phase = "R10 reset";

  // behavioural reference model
  logic [7:0]  fq [2][$];
  logic [7:0]  outq [$];
  int unsigned mCtrl = 0, mMode = 0, mSel = 0, mMask = 0, mStat = 0, mCh = 0;
  int unsigned mLen [2] = '{0, 0};
  int unsigned mRes [2] = '{0, 0};
  bit          mFirst = 0, eValid = 0, eSof = 0, eEof = 0;
  logic [7:0]  eData = 0;

  task automatic modelClear();
    fq[0].delete(); fq[1].delete(); outq.delete();
    mMode = 0; mSel = 0; mMask = 0; mStat = 0; mCh = 0;
    mLen[0] = 0; mLen[1] = 0; mRes[0] = 0; mRes[1] = 0;
    mFirst = 0; eValid = 0; eSof = 0; eEof = 0; eData = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modelClear(); mCtrl = 0;
    end else begin
      int unsigned resPre [2];
      bit busyPre;
      resPre[0] = mRes[0]; resPre[1] = mRes[1];
      busyPre = (outq.size() != 0);
      if (busyPre) begin
        eData = outq.pop_front(); eValid = 1; eSof = mFirst; mFirst = 0;
        eEof = (outq.size() == 0);
        if (outq.size() == 0) mRes[mCh] = 0;
      end else begin
        eData = 0; eValid = 0; eSof = 0; eEof = 0;
      end
      if (wrEn) begin
        case (wrAddr)
          4'd0: begin
            if (wrData[31]) modelClear();
            mCtrl = wrData & 32'h7fff_ffff;
          end
          4'd1: mMode = wrData;
          4'd2: mSel = (wrData < 2) ? wrData : 0;
          4'd3: if (DEPTH - fq[mSel].size() - resPre[mSel] >= 4)
                  for (int b = 0; b < 4; b++) fq[mSel].push_back(wrData[8*b +: 8]);
          4'd4, 4'd5: mLen[wrAddr[0]] = (wrData > DEPTH) ? DEPTH : wrData;
          4'd6, 4'd7: begin
            int unsigned ch, eff;
            ch = wrAddr[0];
            eff = (mLen[ch] > fq[ch].size()) ? fq[ch].size() : mLen[ch];
            if (wrData[0] && mCtrl[0] && !busyPre && eff > 0) begin
              for (int b = 0; b < int'(eff); b++) outq.push_back(fq[ch][b]);
              mRes[ch] = fq[ch].size();
              fq[ch].delete();
              mLen[ch] = 0; mStat |= (1 << ch); mCh = ch; mFirst = 1;
            end
          end
          4'd8: mMask = wrData & 3;
          4'd9: mStat = mStat & ~wrData & 3;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRd(logic [3:0] a);
    case (a)
      4'd0: return mCtrl;
      4'd1: return mMode;
      4'd2: return mSel;
      4'd4: return mLen[0];
      4'd5: return mLen[1];
      4'd8: return mMask;
      4'd9: return mStat;
      default: return 0;
    endcase
  endfunction

  function automatic string rdReq(logic [3:0] a);
    case (a)
      4'd2: return "R1";
      4'd4, 4'd5: return "R3/R6";
      4'd8: return "R9";
      4'd9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s [%s] %s actual=%h expected=%h t=%0t", req, phase, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      chk("R7", "txValid", 32'(txValid), 32'(eValid));
      chk("R7", "txSof",   32'(txSof),   32'(eSof));
      chk("R7", "txEof",   32'(txEof),   32'(eEof));
      chk("R2/R7", "txData", 32'(txData), 32'(eData));
      chk("R8", "irq", 32'(irq), 32'((mStat & mMask) != 0));
      chk(rdReq(rdAddr), "rdData", rdData, expRd(rdAddr));
    end
  end

  function automatic logic [3:0] rdPick(int i);
    case (i)
      0: return 4'd0; 1: return 4'd1; 2: return 4'd2; 3: return 4'd4;
      4: return 4'd5; 5: return 4'd8; default: return 4'd9;
    endcase
  endfunction

  task automatic step(bit en, logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2;
    wrEn = en; wrAddr = a; wrData = d;
    rdAddr = rdPick(rdIdx); rdIdx = (rdIdx + 1) % 7;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 4'd0, 32'd0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=100000 cycles", cyc);
      finishRun();
    end
  end

  initial begin
    @(posedge clk); chkOn = 1'b1;
    idle(2);
    rst_n = 1'b1;
    phase = "R10 reset state"; idle(3);

    phase = "R1 channel select";
    step(1, 2, 1); step(1, 2, 5); step(1, 2, 1); step(1, 2, 2); idle(2);

    phase = "R10 enable";
    step(1, 0, 1);

    phase = "R2 R7 R6 partial frame ch0";
    step(1, 2, 0);
    step(1, 3, 32'h03020100); step(1, 3, 32'h07060504); step(1, 3, 32'h0b0a0908);
    step(1, 4, 10); step(1, 6, 1); idle(14);

    phase = "R5 empty queue launch";
    step(1, 4, 4); step(1, 6, 1); idle(4);

    phase = "R5 length above contents ch1";
    step(1, 2, 1); step(1, 3, 32'hdeadbeef); step(1, 3, 32'h12345678);
    step(1, 5, 20); step(1, 7, 1); idle(12);

    phase = "R4 launch with tx disabled";
    step(1, 0, 0); step(1, 2, 0); step(1, 3, 32'haabbccdd); step(1, 4, 4);
    step(1, 6, 1); idle(3);
    step(1, 0, 1); step(1, 6, 0); idle(2); step(1, 6, 1); idle(8);

    phase = "R4 launch while busy";
    for (int i = 0; i < 4; i++) step(1, 3, 32'h1000 + i);
    step(1, 2, 1); step(1, 3, 32'h55aa55aa);
    step(1, 4, 16); step(1, 5, 4); step(1, 6, 1); step(1, 7, 1); idle(20);
    step(1, 7, 1); idle(8);

    phase = "R3 length clamp";
    step(1, 4, 5000); step(1, 5, DEPTH); step(1, 5, DEPTH + 1); idle(2);
    step(1, 4, 0); step(1, 5, 0);

    phase = "R11 R2 full queue and reservation";
    step(1, 2, 0);
    for (int i = 0; i < DEPTH / 4; i++) step(1, 3, 32'(i * 32'h01010101 + 32'h00030201));
    step(1, 3, 32'hffffffff);
    step(1, 4, 4); step(1, 6, 1);
    for (int i = 0; i < 6; i++) step(1, 3, 32'hc0de0000 + i);
    step(1, 4, 8); idle(2); step(1, 6, 1); idle(12);

    phase = "R8 R9 mask and clear";
    step(1, 8, 1); step(1, 8, 3); idle(1); step(1, 9, 1); idle(1);
    step(1, 9, 2); step(1, 8, 0); idle(1);
    step(1, 8, 2); step(1, 2, 1); step(1, 3, 32'h0000_0042); step(1, 5, 1);
    step(1, 7, 1); idle(3); step(1, 9, 3); idle(2);

    phase = "R10 soft reset mid-frame";
    step(1, 1, 32'h77); step(1, 8, 3); step(1, 2, 0);
    for (int i = 0; i < 4; i++) step(1, 3, 32'h9000 + i);
    step(1, 4, 16); step(1, 6, 1); idle(3);
    step(1, 0, 32'h8000_0005); idle(3);
    step(1, 6, 1); idle(3);

    phase = "random mix R1-R11";
    step(1, 0, 1);
    for (int i = 0; i < 1500; i++) begin
      int unsigned sel;
      logic [31:0] d;
      sel = $urandom % 16;
      case (sel)
        0:       begin d = ($urandom % 40 == 0) ? 32'h8000_0001 : 32'($urandom % 4 != 0); step(1, 0, d); end
        1:       step(1, 1, $urandom);
        2:       step(1, 2, $urandom % 4);
        3,4,5,6,7: step(1, 3, $urandom);
        8:       step(1, 4, $urandom % 48);
        9:       step(1, 5, $urandom % 48);
        10:      step(1, 6, $urandom % 4);
        11:      step(1, 7, $urandom % 4);
        12:      step(1, 8, $urandom);
        13:      step(1, 9, $urandom);
        default: idle(1);
      endcase
    end
    idle(60);
    finishRun();
  end
endmodule